// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front-End

This block is the software-visible face of a serial port. It decodes a 4 KiB window of word-aligned offsets and holds the configuration words: baud divisors, low-power divisor, line control, control, FIFO level select and DMA control. It also keeps the raw interrupt status and the interrupt mask, and drives one level-sensitive interrupt line. Bit timing, FIFO storage and DMA engines are outside the block.

A write to the data word hands its low byte to the transmitter on a one-cycle strobe. A read of the data word pops the head of an external receive FIFO through a simple pop/head port. A flags word reflects the live FIFO status inputs. The last eight words of the window return fixed identification bytes.

The bus side is a plain single-cycle request. `wr_en` or `rd_en` is held for one clock with `addr`. Read data is registered and appears on `rdata` on the clock after the read request, and it holds until the next read.

Top module: `uart_fe_regs`

## Requirements
- R1: After reset the control word (index 12) reads 0x300 and the level select word (index 13) reads 0x12. The other stored words read 0 and `irq` is low. With `tx_empty`=1, `rx_empty`=1 and the other status inputs low, the flags word reads 0x90.
- R2: The register index is `addr[11:2]`. Each configuration word reads back what was written, cut to its width: index 8 low-power divisor (8 bits), index 9 integer divisor (16), index 10 fractional divisor (6), index 11 line control (8), index 12 control (16), index 13 level select (6), index 18 DMA control (3). Read data is valid on `rdata` the cycle after the request.
- R3: Index 14 is the 11-bit mask, index 15 the raw status and index 16 returns raw AND mask. `irq` is high exactly when raw AND mask is nonzero. It changes at the same clock edge that stores a mask or clear write.
- R4: A write to index 0 pulses `tx_valid` during the request cycle, with `tx_data` equal to `wdata[7:0]`, and sets raw bit 5 (transmit).
- R5: A pulse on `rx_arrive` sets raw bit 4 (receive). If it coincides with a clear write, the set wins.
- R6: A write to index 17 clears each raw status bit whose `wdata` bit is 1 and leaves the others.
- R7: The flags word (index 6) reads `{tx_empty, rx_full, tx_full, rx_empty}` in bits 7..4, with 0 elsewhere. Writes to indices 6, 15 and 16 change no state.
- R8: Offsets 0xFE0 + 4k, for k = 0..7, return in order 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: A read of index 0 pulses `rx_pop` for exactly the request cycle and returns `rx_head` zero-extended. No other read pulses `rx_pop`.
- R10: Unmapped offsets read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request, one cycle |
| rd_en | input | 1 | Read request, one cycle |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_head | input | 12 | Receive FIFO head entry |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_arrive | input | 1 | Receive interrupt event pulse |
| irq | output | 1 | Level interrupt |

## Verification
The interrupt path is driven with several patterns. A transmit event with the mask closed shows that raw status and the line are separate. Opening the mask raises the line at once, and clearing drops it, which shows the line's timing. A clear write that coincides with a receive event shows which of the two wins. Address patterns cover every mapped word with all-ones data to expose field widths, the identification words, and unmapped and read-only offsets, to show that they are inert. Data-word reads with distinct head values are compared against non-data reads to confirm the pop strobe.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int IRQ_W  = 11;
    localparam int TX_BIT = 5;
    localparam int RX_BIT = 4;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_FLAG, SEL_ILP, SEL_IBD, SEL_FBD, SEL_LCR,
        SEL_CTL, SEL_LVL, SEL_MSK, SEL_RAW, SEL_MIS, SEL_CLR, SEL_DMA, SEL_ID
    } reg_sel_e;

    typedef struct packed {
        logic [7:0]  ilp;
        logic [15:0] ibd;
        logic [5:0]  fbd;
        logic [7:0]  lcr;
        logic [15:0] ctl;
        logic [5:0]  lvl;
        logic [2:0]  dma;
    } cfg_t;

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0:    id_byte = 8'h11;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-3:0] widx,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);
    localparam int unsigned ID_WORD = (32'(1) << (ADDR_W - 2)) - 8;

    always_comb begin
        int unsigned wi;
        wi     = 32'(widx);
        id_idx = widx[2:0];
        sel    = SEL_NONE;
        if (wi >= ID_WORD) begin
            sel = SEL_ID;
        end else begin
            case (wi)
                0:       sel = SEL_DATA;
                6:       sel = SEL_FLAG;
                8:       sel = SEL_ILP;
                9:       sel = SEL_IBD;
                10:      sel = SEL_FBD;
                11:      sel = SEL_LCR;
                12:      sel = SEL_CTL;
                13:      sel = SEL_LVL;
                14:      sel = SEL_MSK;
                15:      sel = SEL_RAW;
                16:      sel = SEL_MIS;
                17:      sel = SEL_CLR;
                18:      sel = SEL_DMA;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/uart_fe_cfg.sv
module uart_fe_cfg
    import uart_fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [15:0] wdata,
    output cfg_t        cfg_q
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel)
                SEL_ILP: cfg_d.ilp = wdata[7:0];
                SEL_IBD: cfg_d.ibd = wdata[15:0];
                SEL_FBD: cfg_d.fbd = wdata[5:0];
                SEL_LCR: cfg_d.lcr = wdata[7:0];
                SEL_CTL: cfg_d.ctl = wdata[15:0];
                SEL_LVL: cfg_d.lvl = wdata[5:0];
                SEL_DMA: cfg_d.dma = wdata[2:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.ctl <= 16'h0300;
            cfg_q.lvl <= 6'h12;
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq
    import uart_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mask,
    input  logic             wr_clr,
    input  logic             tx_set,
    input  logic             rx_set,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] raw_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic             irq_q
);
    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic [IRQ_W-1:0] mask;
        logic             irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask) st_d.mask = wdata;
        if (wr_clr)  st_d.raw  = st_q.raw & ~wdata;
        if (tx_set)  st_d.raw[TX_BIT] = 1'b1;
        if (rx_set)  st_d.raw[RX_BIT] = 1'b1;
        st_d.irq = |(st_d.raw & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int HEAD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic [HEAD_W-1:0] rx_head,
    input  logic              rx_empty,
    input  logic              rx_full,
    output logic              rx_pop,
    input  logic              rx_arrive,
    output logic              irq
);
    reg_sel_e         sel;
    logic [2:0]       id_idx;
    cfg_t             cfg_q;
    logic [IRQ_W-1:0] raw_q, mask_q;
    logic [DATA_W-1:0] rd_val, rdata_d, rdata_q;
    logic             unused_hi;

    assign unused_hi = ^{wdata[DATA_W-1:16], addr[1:0]};

    uart_fe_decode #(.ADDR_W(ADDR_W)) u_dec (
        .widx   (addr[ADDR_W-1:2]),
        .sel    (sel),
        .id_idx (id_idx)
    );

    uart_fe_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wdata[15:0]),
        .cfg_q (cfg_q)
    );

    uart_fe_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_en && sel == SEL_MSK),
        .wr_clr  (wr_en && sel == SEL_CLR),
        .tx_set  (tx_valid),
        .rx_set  (rx_arrive),
        .wdata   (wdata[IRQ_W-1:0]),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq_q   (irq)
    );

    assign tx_valid = wr_en && sel == SEL_DATA;
    assign tx_data  = wdata[7:0];
    assign rx_pop   = rd_en && sel == SEL_DATA;

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_DATA: rd_val[HEAD_W-1:0] = rx_head;
            SEL_FLAG: rd_val[7:4]        = {tx_empty, rx_full, tx_full, rx_empty};
            SEL_ILP:  rd_val[7:0]        = cfg_q.ilp;
            SEL_IBD:  rd_val[15:0]       = cfg_q.ibd;
            SEL_FBD:  rd_val[5:0]        = cfg_q.fbd;
            SEL_LCR:  rd_val[7:0]        = cfg_q.lcr;
            SEL_CTL:  rd_val[15:0]       = cfg_q.ctl;
            SEL_LVL:  rd_val[5:0]        = cfg_q.lvl;
            SEL_MSK:  rd_val[IRQ_W-1:0]  = mask_q;
            SEL_RAW:  rd_val[IRQ_W-1:0]  = raw_q;
            SEL_MIS:  rd_val[IRQ_W-1:0]  = raw_q & mask_q;
            SEL_DMA:  rd_val[2:0]        = cfg_q.dma;
            SEL_ID:   rd_val[7:0]        = id_byte(id_idx);
            default:  rd_val             = '0;
        endcase
        rdata_d = rd_en ? rd_val : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int HEAD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              tx_valid,
    input logic [HEAD_W-1:0] rx_head,
    input logic              rx_pop,
    input logic              rx_arrive,
    input logic              irq,
    input logic [IRQ_W-1:0]  raw,
    input logic [IRQ_W-1:0]  mask
);
    logic [ADDR_W-3:0] widx;
    logic              inert_wr;
    assign widx     = addr[ADDR_W-1:2];
    assign inert_wr = wr_en && !rx_arrive &&
                      (widx == (ADDR_W-2)'(6) || widx == (ADDR_W-2)'(15) ||
                       widx == (ADDR_W-2)'(16));

    assert_irq_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(raw & mask));

    assert_tx_sets_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> raw[TX_BIT]);

    assert_rx_sets_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_arrive |=> raw[RX_BIT]);

    assert_clear_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rx_arrive && widx == (ADDR_W-2)'(17))
        |=> ((raw & $past(wdata[IRQ_W-1:0])) == '0));

    assert_inert_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inert_wr |=> ($stable(raw) && $stable(mask)));

    assert_pop_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> (rdata[HEAD_W-1:0] == $past(rx_head) &&
                    rdata[DATA_W-1:HEAD_W] == '0));
endmodule

bind uart_fe_regs uart_fe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HEAD_W(HEAD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .tx_valid  (tx_valid),
    .rx_head   (rx_head),
    .rx_pop    (rx_pop),
    .rx_arrive (rx_arrive),
    .irq       (irq),
    .raw       (raw_q),
    .mask      (mask_q)
);

// File: tb/sim_uart_fe_regs.sv
module sim_uart_fe_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_empty = 1'b1, tx_full = 1'b0;
    logic [11:0] rx_head = '0;
    logic        rx_empty = 1'b1, rx_full = 1'b0;
    logic        rx_pop;
    logic        rx_arrive = 1'b0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    logic seen_pop, seen_tx;
    logic [7:0] seen_byte;

    always #10 clk = ~clk;

    uart_fe_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_head(rx_head),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_pop(rx_pop),
        .rx_arrive(rx_arrive), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        #1;
        seen_tx = tx_valid; seen_byte = tx_data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        seen_pop = rx_pop;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        seen_pop = seen_pop | rx_pop;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(12'h030, v); chk("R1 ctl", v, 32'h300);
        rd(12'h034, v); chk("R1 lvl", v, 32'h12);
        rd(12'h038, v); chk("R1 mask", v, 32'h0);
        rd(12'h03C, v); chk("R1 raw", v, 32'h0);
        rd(12'h024, v); chk("R1 ibd", v, 32'h0);
        rd(12'h018, v); chk("R1 flags", v, 32'h90);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, v); chk("R2 ilp", v, 32'hFF);
        wr(12'h024, 32'hFFFF_FFFF); rd(12'h024, v); chk("R2 ibd", v, 32'hFFFF);
        wr(12'h028, 32'hFFFF_FFFF); rd(12'h028, v); chk("R2 fbd", v, 32'h3F);
        wr(12'h02C, 32'hFFFF_FFFF); rd(12'h02C, v); chk("R2 lcr", v, 32'hFF);
        wr(12'h034, 32'hFFFF_FFFF); rd(12'h034, v); chk("R2 lvl", v, 32'h3F);
        wr(12'h048, 32'hFFFF_FFFF); rd(12'h048, v); chk("R2 dma", v, 32'h7);
        wr(12'h030, 32'h0000_A5C3); rd(12'h030, v); chk("R2 ctl", v, 32'hA5C3);
        wr(12'h024, 32'h0000_1234); rd(12'h024, v); chk("R2 ibd pattern", v, 32'h1234);
        rd(12'h020, v); chk("R2 ilp kept", v, 32'hFF);
    endtask

    task automatic t_tx_irq;
        logic [31:0] v;
        wr(12'h000, 32'h0000_015A);
        chk("R4 strobe", {31'b0, seen_tx}, 32'h1);
        chk("R4 byte", {24'b0, seen_byte}, 32'h5A);
        chk("R3 masked off", {31'b0, irq}, 32'h0);
        rd(12'h03C, v); chk("R4 raw tx", v, 32'h20);
        rd(12'h040, v); chk("R3 mis closed", v, 32'h0);
        wr(12'h038, 32'h0000_0020);
        chk("R3 irq on mask", {31'b0, irq}, 32'h1);
        rd(12'h040, v); chk("R3 mis open", v, 32'h20);
        wr(12'h044, 32'h0000_0010);
        chk("R6 other bit kept", {31'b0, irq}, 32'h1);
        wr(12'h044, 32'h0000_0020);
        chk("R6 irq dropped", {31'b0, irq}, 32'h0);
        rd(12'h03C, v); chk("R6 raw cleared", v, 32'h0);
        wr(12'h030, 32'h0000_0300);
        chk("R4 no strobe elsewhere", {31'b0, seen_tx}, 32'h0);
    endtask

    task automatic t_rx;
        logic [31:0] v;
        wr(12'h038, 32'h0000_0010);
        @(negedge clk); rx_arrive = 1'b1;
        @(negedge clk); rx_arrive = 1'b0;
        chk("R5 irq on rx", {31'b0, irq}, 32'h1);
        rd(12'h03C, v); chk("R5 raw rx", v, 32'h10);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h044; wdata = 32'h7FF; rx_arrive = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rx_arrive = 1'b0;
        rd(12'h03C, v); chk("R5 set beats clear", v, 32'h10);
        wr(12'h044, 32'h0000_07FF);
        chk("R6 clear all", {31'b0, irq}, 32'h0);
        wr(12'h038, 32'h0);
    endtask

    task automatic t_flags;
        logic [31:0] v;
        tx_empty = 1'b0; rx_full = 1'b1; tx_full = 1'b1; rx_empty = 1'b0;
        rd(12'h018, v); chk("R7 flags pattern", v, 32'h60);
        tx_empty = 1'b1; rx_full = 1'b0; tx_full = 1'b0; rx_empty = 1'b1;
        wr(12'h000, 32'h0);
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h03C, 32'hFFFF_FFFF);
        wr(12'h040, 32'hFFFF_FFFF);
        rd(12'h03C, v); chk("R7 raw untouched", v, 32'h20);
        rd(12'h038, v); chk("R7 mask untouched", v, 32'h0);
        rd(12'h018, v); chk("R7 flags live", v, 32'h90);
        wr(12'h044, 32'h7FF);
    endtask

    task automatic t_id;
        logic [31:0] v;
        logic [7:0] exp_id [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(4 * k), v);
            chk("R8 id byte", v, {24'b0, exp_id[k]});
        end
    endtask

    task automatic t_pop;
        logic [31:0] v;
        rx_head = 12'h4A7;
        rd(12'h000, v);
        chk("R9 pop pulse", {31'b0, seen_pop}, 32'h1);
        chk("R9 head", v, 32'h4A7);
        chk("R9 pop ends", {31'b0, rx_pop}, 32'h0);
        rx_head = 12'h0C3;
        rd(12'h000, v); chk("R9 head 2", v, 32'h0C3);
        rd(12'h030, v);
        chk("R9 no pop on other read", {31'b0, seen_pop}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h04C, 32'hFFFF_FFFF);
        wr(12'hFDC, 32'hFFFF_FFFF);
        rd(12'h004, v); chk("R10 read 0x004", v, 32'h0);
        rd(12'h014, v); chk("R10 read 0x014", v, 32'h0);
        rd(12'h04C, v); chk("R10 read 0x04C", v, 32'h0);
        rd(12'hFDC, v); chk("R10 read 0xFDC", v, 32'h0);
        rd(12'h030, v); chk("R10 ctl untouched", v, 32'h300);
        rd(12'h038, v); chk("R10 mask untouched", v, 32'h0);
        rd(12'h03C, v); chk("R10 raw untouched", v, 32'h0);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        t_tx_irq;
        t_rx;
        t_flags;
        t_id;
        t_pop;
        t_unmapped;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule